// File: doc/BRIEF.md
# Configurable Dual-Table Logic Cell

This block is one programmable logic cell for a fabric of identical tiles. It holds two 3-input look-up tables whose contents come from a static configuration port. The lowest index input of each table is not a pin: it is the NAND of two cell pins. Each table therefore looks at four raw pins and can build a useful subset of 4-input functions. A multiplexer picks one of the two table outputs and feeds it to a single register. The multiplexer is steered either by a configuration bit or by a dedicated select pin, and a further configuration bit chooses between the two. The cell output is either the register or the multiplexer output, as configuration selects.

The register is a mux-scan flop clocked by the ordinary system clock. When scan enable is high it loads the scan input in place of functional data. Its value always appears on the scan output, so cells placed side by side form one serial scan string that moves one bit per clock. Two re-drive inverters, each with its own 3-bit source selector, let the surrounding fabric tap and re-buffer any of eight cell signals. The register's next-value choice is modelled as a three-way capture mode: CAP_RESET when reset is high, otherwise CAP_SCAN when scan enable is high, otherwise CAP_FUNC. The mode is set fresh in every cycle from the current inputs and has no transitions of its own.

Top module: `dual_lut_cell`

## Requirements
- R1: Table 0 output equals `tbl_cfg[0][idx]` with idx = {`tbl_pins[0][3]`, `tbl_pins[0][2]`, NAND(`tbl_pins[0][1]`, `tbl_pins[0][0]`)}; it is seen on an inverter whose selector is 4.
- R2: Table 1 follows the same rule on `tbl_pins[1]` and `tbl_cfg[1]`; it is seen on an inverter whose selector is 5.
- R3: The multiplexer outputs table 1 when its select is 1 and table 0 when it is 0; the select is `sel_pin` when `cfg_sel_src` is 1 and `cfg_sel_bit` when it is 0, and the unused one has no effect.
- R4: With reset low and `scan_en` low, the register loads the multiplexer output at the rising clock edge.
- R5: With reset low and `scan_en` high, the register loads `scan_in` and functional data has no effect; `scan_out` always equals the register.
- R6: Reset is synchronous and active high; it clears the register to 0 and wins over both scan and functional capture.
- R7: `cell_out` is the register when `cfg_out_reg` is 1 and the combinational multiplexer output when it is 0.
- R8: Each inverter outputs the inverse of the source its 3-bit selector names: 0 `tbl_pins[0][2]`, 1 `tbl_pins[0][3]`, 2 `tbl_pins[1][2]`, 3 `tbl_pins[1][3]`, 4 table 0, 5 table 1, 6 register, 7 multiplexer output.
- R9: Cells chained scan output to scan input, with scan enable high, shift one bit per clock, so a bit entering the first of N cells leaves the last after N edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used for scan |
| rst | input | 1 | Synchronous active-high reset of the register |
| tbl_pins | input | 2x4 | Raw pins of each table; bits 0 and 1 go through the NAND |
| sel_pin | input | 1 | Pin select for the table multiplexer |
| scan_en | input | 1 | Load scan data instead of functional data |
| scan_in | input | 1 | Serial scan data in |
| tbl_cfg | input | 2x8 | Contents of each table |
| cfg_sel_bit | input | 1 | Configured select value for the multiplexer |
| cfg_sel_src | input | 1 | 1 = use sel_pin, 0 = use cfg_sel_bit |
| cfg_out_reg | input | 1 | 1 = registered output, 0 = combinational |
| inv_sel | input | 2x3 | Source selector of each re-drive inverter |
| cell_out | output | 1 | Cell output |
| scan_out | output | 1 | Serial scan data out, the register value |
| inv_out | output | 2 | Outputs of the re-drive inverters |

## Verification
The hardest case to reach from the ports is a table read in which the NAND position is 0, which needs both gated pins high at once while the chosen configuration bit differs from its neighbour. Uniform random pins give this only one time in four per table, so the random loop also randomizes table contents every cycle and runs several hundred cycles, and the table outputs are read directly through the inverters with selectors 4 and 5 rather than only through the multiplexer. Reset priority over scan and the chain's shift timing are driven by directed sequences.

// File: rtl/dual_lut_cell_pkg.sv
package dual_lut_cell_pkg;

    typedef enum logic [1:0] {
        CAP_RESET = 2'd0,
        CAP_SCAN  = 2'd1,
        CAP_FUNC  = 2'd2
    } cap_mode_e;

    localparam int unsigned INV_SEL_W = 3;
    localparam int unsigned INV_SRC_N = 1 << INV_SEL_W;

    typedef enum logic [INV_SEL_W-1:0] {
        SRC_T0_P2 = 3'd0,
        SRC_T0_P3 = 3'd1,
        SRC_T1_P2 = 3'd2,
        SRC_T1_P3 = 3'd3,
        SRC_T0    = 3'd4,
        SRC_T1    = 3'd5,
        SRC_REG   = 3'd6,
        SRC_MUX   = 3'd7
    } inv_src_e;

endpackage

// File: rtl/dlc_table.sv
module dlc_table #(
    parameter int unsigned LUT_INPUTS = 3,
    localparam int unsigned PINS      = LUT_INPUTS + 1,
    localparam int unsigned LUT_SIZE  = 1 << LUT_INPUTS
) (
    input  logic [PINS-1:0]     pins,
    input  logic [LUT_SIZE-1:0] cfg,
    output logic                y
);

    logic                  gated;
    logic [LUT_INPUTS-1:0] idx;

    // pins 0 and 1 combine through the NAND into index bit 0
    assign gated = ~(pins[0] & pins[1]);
    assign idx   = {pins[PINS-1:2], gated};
    assign y     = cfg[idx];

endmodule

// File: rtl/dlc_capture_reg.sv
module dlc_capture_reg
    import dual_lut_cell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  logic scan_in,
    input  logic d,
    output logic q
);

    cap_mode_e mode;
    logic      q_next;

    always_comb begin
        if (rst)
            mode = CAP_RESET;
        else if (scan_en)
            mode = CAP_SCAN;
        else
            mode = CAP_FUNC;
    end

    always_comb begin
        unique case (mode)
            CAP_RESET: q_next = 1'b0;
            CAP_SCAN:  q_next = scan_in;
            CAP_FUNC:  q_next = d;
            default:   q_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_next;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q == 1'b0)); // R6

    AST_SCAN_LOADS: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (q == $past(scan_in))); // R5

    AST_FUNC_LOADS: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (q == $past(d))); // R4

endmodule

// File: rtl/dlc_redrive.sv
module dlc_redrive
    import dual_lut_cell_pkg::*;
(
    input  logic [INV_SRC_N-1:0] sources,
    input  logic [INV_SEL_W-1:0] sel,
    output logic                 y
);

    assign y = ~sources[sel];

endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell
    import dual_lut_cell_pkg::*;
#(
    parameter int unsigned LUT_INPUTS = 3,
    parameter int unsigned NUM_INV    = 2,
    localparam int unsigned PINS      = LUT_INPUTS + 1,
    localparam int unsigned LUT_SIZE  = 1 << LUT_INPUTS
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [1:0][PINS-1:0]               tbl_pins,
    input  logic                               sel_pin,
    input  logic                               scan_en,
    input  logic                               scan_in,
    input  logic [1:0][LUT_SIZE-1:0]           tbl_cfg,
    input  logic                               cfg_sel_bit,
    input  logic                               cfg_sel_src,
    input  logic                               cfg_out_reg,
    input  logic [NUM_INV-1:0][INV_SEL_W-1:0]  inv_sel,
    output logic                               cell_out,
    output logic                               scan_out,
    output logic [NUM_INV-1:0]                 inv_out
);

    logic [1:0]           tbl_y;
    logic                 mux_sel;
    logic                 mux_y;
    logic                 q;
    logic [INV_SRC_N-1:0] taps;

    for (genvar t = 0; t < 2; t++) begin : g_table
        dlc_table #(.LUT_INPUTS(LUT_INPUTS)) u_table (
            .pins (tbl_pins[t]),
            .cfg  (tbl_cfg[t]),
            .y    (tbl_y[t])
        );
    end

    assign mux_sel = cfg_sel_src ? sel_pin : cfg_sel_bit;
    assign mux_y   = mux_sel ? tbl_y[1] : tbl_y[0];

    dlc_capture_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .scan_in (scan_in),
        .d       (mux_y),
        .q       (q)
    );

    assign cell_out = cfg_out_reg ? q : mux_y;
    assign scan_out = q;

    always_comb begin
        taps          = '0;
        taps[SRC_T0_P2] = tbl_pins[0][2];
        taps[SRC_T0_P3] = tbl_pins[0][PINS-1];
        taps[SRC_T1_P2] = tbl_pins[1][2];
        taps[SRC_T1_P3] = tbl_pins[1][PINS-1];
        taps[SRC_T0]    = tbl_y[0];
        taps[SRC_T1]    = tbl_y[1];
        taps[SRC_REG]   = q;
        taps[SRC_MUX]   = mux_y;
    end

    for (genvar k = 0; k < NUM_INV; k++) begin : g_inv
        dlc_redrive u_inv (
            .sources (taps),
            .sel     (inv_sel[k]),
            .y       (inv_out[k])
        );
    end

    AST_REG_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_out_reg && $past(cfg_out_reg) && !$past(rst) && !$past(scan_en))
        |-> (cell_out == $past(mux_y))); // R7

    AST_SCAN_OUT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (scan_out == $past(scan_in))); // R9

endmodule

// File: tb/dual_lut_cell_tb.sv
`timescale 1ns/1ps
module dual_lut_cell_tb;

    localparam int NCHAIN = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0][3:0] tbl_pins;
    logic            sel_pin, scan_en, scan_in;
    logic [1:0][7:0] tbl_cfg;
    logic            cfg_sel_bit, cfg_sel_src, cfg_out_reg;
    logic [1:0][2:0] inv_sel;
    logic            cell_out, scan_out;
    logic [1:0]      inv_out;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;
    logic exp_q;

    always #2 clk = ~clk;

    dual_lut_cell u_dut (
        .clk(clk), .rst(rst), .tbl_pins(tbl_pins), .sel_pin(sel_pin),
        .scan_en(scan_en), .scan_in(scan_in), .tbl_cfg(tbl_cfg),
        .cfg_sel_bit(cfg_sel_bit), .cfg_sel_src(cfg_sel_src),
        .cfg_out_reg(cfg_out_reg), .inv_sel(inv_sel),
        .cell_out(cell_out), .scan_out(scan_out), .inv_out(inv_out)
    );

    // short scan string of tiled cells
    logic            ch_scan_en, ch_in;
    logic [NCHAIN:0] ch_link;
    assign ch_link[0] = ch_in;
    for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
        logic       unused_out;
        logic [1:0] unused_inv;
        dual_lut_cell u_cell (
            .clk(clk), .rst(rst), .tbl_pins('0), .sel_pin(1'b0),
            .scan_en(ch_scan_en), .scan_in(ch_link[c]), .tbl_cfg('0),
            .cfg_sel_bit(1'b0), .cfg_sel_src(1'b0), .cfg_out_reg(1'b1),
            .inv_sel('0), .cell_out(unused_out), .scan_out(ch_link[c+1]),
            .inv_out(unused_inv)
        );
    end

    function automatic logic m_table(input logic [7:0] cfg, input logic [3:0] p);
        logic [2:0] idx;
        idx = {p[3], p[2], ~(p[0] & p[1])};
        return cfg[idx];
    endfunction

    function automatic logic m_mux();
        logic s;
        s = cfg_sel_src ? sel_pin : cfg_sel_bit;
        return s ? m_table(tbl_cfg[1], tbl_pins[1]) : m_table(tbl_cfg[0], tbl_pins[0]);
    endfunction

    function automatic logic m_tap(input logic [2:0] s);
        case (s)
            3'd0: return tbl_pins[0][2];
            3'd1: return tbl_pins[0][3];
            3'd2: return tbl_pins[1][2];
            3'd3: return tbl_pins[1][3];
            3'd4: return m_table(tbl_cfg[0], tbl_pins[0]);
            3'd5: return m_table(tbl_cfg[1], tbl_pins[1]);
            3'd6: return exp_q;
            default: return m_mux();
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_next();
        if (rst) return 1'b0;
        if (scan_en) return scan_in;
        return m_mux();
    endfunction

    task automatic tick();
        logic nx;
        nx = m_next();
        @(posedge clk);
        exp_q = nx;
        @(negedge clk);
    endtask

    task automatic check_inv(input int k);
        string tag;
        tag = (inv_sel[k] == 3'd4) ? "R1" : (inv_sel[k] == 3'd5) ? "R2" : "R8";
        check(tag, inv_out[k], ~m_tap(inv_sel[k]));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tbl_pins = '0; sel_pin = 0; scan_en = 0; scan_in = 0;
        tbl_cfg = '0; cfg_sel_bit = 0; cfg_sel_src = 0; cfg_out_reg = 1;
        inv_sel = '0; ch_scan_en = 0; ch_in = 0; exp_q = 1'bx;
        @(negedge clk);
        tick(); tick();
        // reset state, R6
        check("R6 reset state", scan_out, 1'b0);
        check("R6 reset state cell_out", cell_out, 1'b0);

        // R6: reset wins over scan
        scan_en = 1; scan_in = 1;
        tick();
        check("R6 reset over scan", scan_out, 1'b0);
        scan_en = 0; tbl_cfg = 16'hFFFF;
        tick();
        check("R6 reset over func", scan_out, 1'b0);
        rst = 0;

        // R3: select source, directed
        tbl_cfg[0] = 8'h00; tbl_cfg[1] = 8'hFF; cfg_out_reg = 0;
        cfg_sel_src = 1; sel_pin = 0; cfg_sel_bit = 1; #1;
        check("R3 pin sel 0", cell_out, 1'b0);
        sel_pin = 1; cfg_sel_bit = 0; #1;
        check("R3 pin sel 1", cell_out, 1'b1);
        cfg_sel_src = 0; cfg_sel_bit = 1; sel_pin = 0; #1;
        check("R3 cfg bit ignores pin", cell_out, 1'b1);
        cfg_sel_bit = 0; sel_pin = 1; #1;
        check("R3 cfg bit 0", cell_out, 1'b0);

        // R1: NAND position, both gated pins high selects index bit0 = 0
        tbl_cfg[0] = 8'b0000_0010; tbl_pins[0] = 4'b0011; inv_sel[0] = 3'd4; #1;
        check("R1 nand low", inv_out[0], 1'b1);
        tbl_pins[0] = 4'b0001; #1;
        check("R1 nand high", inv_out[0], 1'b0);

        // R5: scan ignores functional data
        @(negedge clk);
        scan_en = 1; scan_in = 1; cfg_out_reg = 1; tbl_cfg = '0;
        tick();
        check("R5 scan load", scan_out, 1'b1);
        scan_en = 0;
        tick();
        check("R4 func load", scan_out, 1'b0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            string rtag;
            rtag = rst ? "R6" : scan_en ? "R5" : "R4";
            check(rtag, scan_out, exp_q);
            if (cfg_out_reg) check("R7 registered", cell_out, exp_q);
            rst         = ($urandom_range(0, 15) == 0);
            tbl_pins    = 8'($urandom);
            tbl_cfg     = 16'($urandom);
            sel_pin     = 1'($urandom);
            scan_en     = ($urandom_range(0, 3) == 0);
            scan_in     = 1'($urandom);
            cfg_sel_bit = 1'($urandom);
            cfg_sel_src = 1'($urandom);
            cfg_out_reg = 1'($urandom);
            inv_sel     = 6'($urandom);
            #1;
            if (!cfg_out_reg) check("R7 R3 combinational", cell_out, m_mux());
            check_inv(0);
            check_inv(1);
            tick();
        end
        rst = 0;

        // R9: chain shift
        begin
            logic [7:0] pat;
            pat = 8'b1011_0110;
            ch_scan_en = 1;
            for (int e = 0; e < 8; e++) begin
                ch_in = pat[e];
                @(posedge clk); @(negedge clk);
                if (e >= NCHAIN - 1)
                    check("R9 chain shift", ch_link[NCHAIN], pat[e-(NCHAIN-1)]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule